// File: doc/BRIEF.md
# Packed Byte Horizontal-Add Unit

This unit is an execute-stage datapath for pixel work. It views one 32-bit operand as four unsigned bytes and adds those bytes to one another. It does not pair bytes of two different registers. Two 4-bit masks shape the reduction:
- one mask selects which bytes are doubled;
- in the richest mode, the other mask selects which bytes take part at all.

The reduced value is clamped to one byte. Typical uses are filter taps and predictor averages in which the samples already sit packed side by side in one word.

A fourth operation code adds the two 32-bit operands and shifts the sum right by a 5-bit immediate. This gives rounded averages when a rounding offset is passed as the second operand.

Every operation is accepted on a cycle with `in_valid` high. Its result appears registered on the next cycle, and a new operation may be issued on every cycle. Instruction decode, the register file and the pipeline control sit outside the block.

Top module: `hadd_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` is 1 in exactly the cycle after each cycle with `in_valid` high, and 0 otherwise. Issue on consecutive cycles produces a result on each of the following cycles.
- R3: With `op` = 2'b00, the four bytes of `src_a` are summed (lane i is `src_a[8i+7:8i]`, lane 0 least significant). Both masks and `src_b` have no effect.
- R4: In every byte-reduction mode (`op` 00, 01 or 10), a sum above 255 yields 255, and `result[31:8]` is 0.
- R5: With `op` = 2'b01, all four lanes are summed, and lane i is doubled when `mask_dbl[i]` is 1. `mask_sel` has no effect.
- R6: With `op` = 2'b10, lane i is summed only when `mask_sel[i]` is 1. A summed lane is doubled when `mask_dbl[i]` is 1, and `mask_dbl[i]` has no effect for an unselected lane.
- R7: With `op` = 2'b11, `result` = ((`src_a` + `src_b`) mod 2^32) logically shifted right by `shamt` (0 to 31). The carry out of bit 31 is discarded.
- R8: In a cycle after one with `in_valid` low, `result` keeps its previous value whatever the other inputs were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe for the operands on this cycle |
| op | input | 2 | 00 plain sum, 01 doubled-lane sum, 10 selected-and-doubled sum, 11 add then shift right |
| src_a | input | 32 | Packed byte source; first addend for add-shift |
| src_b | input | 32 | Second addend for add-shift |
| mask_sel | input | 4 | Lane participation mask (mode 10) |
| mask_dbl | input | 4 | Lane doubling mask (modes 01 and 10) |
| shamt | input | 5 | Right shift amount for add-shift |
| out_valid | output | 1 | Result valid, one cycle after issue |
| result | output | 32 | Registered result |

## Verification
The block's only state is the result register and its valid flag. Any wrong lane weighting, mask decode or clamp therefore shows up in `result` on the first cycle after the offending issue. There is no later point at which such an error could surface or be hidden.

A stuck or delayed valid flag shows as a missing or extra `out_valid` pulse in the very next cycle. A lost hold shows as a changed `result` after an idle cycle.

Random operands across all four codes, together with directed values near the 255 clamp, exercise the mask combinations, the carry drop and the shift extremes.

// File: rtl/hadd_unit.sv
module hadd_unit #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [1:0]                     op,
  input  logic [LANE_W*LANES-1:0]        src_a,
  input  logic [LANE_W*LANES-1:0]        src_b,
  input  logic [LANES-1:0]               mask_sel,
  input  logic [LANES-1:0]               mask_dbl,
  input  logic [$clog2(LANE_W*LANES)-1:0] shamt,
  output logic                           out_valid,
  output logic [LANE_W*LANES-1:0]        result
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int SUM_W  = LANE_W + 1 + $clog2(LANES);
  localparam logic [1:0] OP_PLAIN = 2'b00;
  localparam logic [1:0] OP_DBL   = 2'b01;
  localparam logic [1:0] OP_SEL   = 2'b10;
  localparam logic [1:0] OP_ADDSH = 2'b11;
  localparam logic [SUM_W-1:0] SAT_MAX = SUM_W'((1 << LANE_W) - 1);

  logic [SUM_W-1:0] term [LANES];
  logic [SUM_W-1:0] lane_sum;
  logic [LANE_W-1:0] sat_byte;
  logic [DATA_W-1:0] wide_sum;
  logic [DATA_W-1:0] next_res;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] byte_v;
    logic incl, dbl;
    assign byte_v  = src_a[i*LANE_W +: LANE_W];
    assign incl    = (op == OP_SEL) ? mask_sel[i] : 1'b1;
    assign dbl     = (op == OP_DBL || op == OP_SEL) && mask_dbl[i];
    assign term[i] = !incl ? '0 :
                     dbl   ? SUM_W'({byte_v, 1'b0}) : SUM_W'(byte_v);
  end

  always_comb begin
    lane_sum = '0;
    for (int i = 0; i < LANES; i++) lane_sum = lane_sum + term[i];
  end

  assign sat_byte = (lane_sum > SAT_MAX) ? '1 : lane_sum[LANE_W-1:0];
  assign wide_sum = src_a + src_b;
  assign next_res = (op == OP_ADDSH) ? (wide_sum >> shamt)
                                     : DATA_W'(sat_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  p_byte_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != OP_ADDSH) |=> (result[DATA_W-1:LANE_W] == '0));
  p_addsh_noshift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ADDSH && shamt == '0) |=> (result == $past(src_a + src_b)));
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && result == '0));
endmodule

// File: tb/test_hadd_unit.sv
module test_hadd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] src_a = '0, src_b = '0;
  logic [3:0]  mask_sel = '0, mask_dbl = '0;
  logic [4:0]  shamt = '0;
  logic        out_valid;
  logic [31:0] result;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hadd_unit i_hadd_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .mask_sel(mask_sel), .mask_dbl(mask_dbl),
    .shamt(shamt), .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] ref_model(input logic [1:0] o, input logic [31:0] a, b,
                                            input logic [3:0] ms, md, input logic [4:0] sh);
    int acc = 0;
    if (o == 2'b11) return (a + b) >> sh;
    for (int i = 0; i < 4; i++) begin
      int v = int'(a[8*i +: 8]);
      bit take = (o == 2'b10) ? ms[i] : 1'b1;
      bit twice = (o != 2'b00) && md[i];
      if (take) acc += twice ? 2 * v : v;
    end
    return (acc > 255) ? 32'd255 : 32'(acc);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a negedge; drives, then compares at the next negedge.
  task automatic issue(input logic [1:0] o, input logic [31:0] a, b,
                       input logic [3:0] ms, md, input logic [4:0] sh, input string tag);
    logic [31:0] exp;
    exp = ref_model(o, a, b, ms, md, sh);
    op = o; src_a = a; src_b = b; mask_sel = ms; mask_dbl = md; shamt = sh;
    in_valid = 1'b1;
    @(negedge clk);
    check("R2 out_valid", {31'b0, out_valid}, 32'd1);
    check(tag, result, exp);
  endtask

  task automatic idle_check();
    logic [31:0] prev;
    prev = result;
    in_valid = 1'b0;
    op = 2'($urandom); src_a = $urandom; src_b = $urandom;
    mask_sel = 4'($urandom); mask_dbl = 4'($urandom); shamt = 5'($urandom);
    @(negedge clk);
    check("R2 idle out_valid", {31'b0, out_valid}, 32'd0);
    check("R8 hold", result, prev);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    string tg;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 reset result", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(2'b00, 32'h01020304, 32'hFFFFFFFF, 4'hF, 4'hF, 5'd7, "R3 masks ignored");
    issue(2'b00, 32'h3F3F3F3F, 32'h0, 4'h0, 4'h0, 5'd0, "R3 plain 252");
    issue(2'b00, 32'h40404040, 32'h0, 4'h0, 4'h0, 5'd0, "R4 clamp at 256");
    issue(2'b00, 32'hFFFFFFFF, 32'h0, 4'h0, 4'h0, 5'd0, "R4 clamp max");
    issue(2'b01, 32'h00000005, 32'h0, 4'h0, 4'h1, 5'd0, "R5 lane0 doubled, sel ignored");
    issue(2'b01, 32'h20202020, 32'h0, 4'hF, 4'hF, 5'd0, "R5 R4 doubled clamp");
    issue(2'b01, 32'h7F000000, 32'h0, 4'h0, 4'h8, 5'd0, "R5 lane3 doubled 254");
    issue(2'b10, 32'hFFFFFFFF, 32'h0, 4'h0, 4'hF, 5'd0, "R6 none selected");
    issue(2'b10, 32'h00110000, 32'h0, 4'h4, 4'hB, 5'd0, "R6 selected not doubled");
    issue(2'b10, 32'h80000001, 32'h0, 4'h8, 4'h9, 5'd0, "R6 R4 lane3 doubled clamp");
    issue(2'b10, 32'h0A0B0C0D, 32'h0, 4'h5, 4'hA, 5'd0, "R6 dbl ignored unselected");
    issue(2'b11, 32'hFFFFFFFF, 32'h1, 4'hF, 4'hF, 5'd0, "R7 carry discarded");
    issue(2'b11, 32'h80000000, 32'h0, 4'h0, 4'h0, 5'd31, "R7 shift 31");
    issue(2'b11, 32'd100, 32'd100, 4'h0, 4'h0, 5'd3, "R7 avg 25");
    idle_check();
    idle_check();

    for (int k = 0; k < 3000; k++) begin
      logic [1:0] o;
      o = 2'($urandom);
      case (o)
        2'b00: tg = "R3 random";
        2'b01: tg = "R5 random";
        2'b10: tg = "R6 random";
        default: tg = "R7 random";
      endcase
      issue(o, $urandom, $urandom, 4'($urandom), 4'($urandom), 5'($urandom), tg);
      if ($urandom_range(0, 9) == 0) idle_check();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule